// File: doc/BRIEF.md
# Serial Receive Queue with Fill-Level Flags

This block sits between a serial receive engine and the host. Each byte the engine delivers is written into a 16-entry first-in first-out queue. The host takes bytes out again through a small register interface. Two flags describe how full the queue is. The full flag turns on once the number of stored bytes reaches a level the host programs. The data-ready flag covers the case of a queue that holds bytes but has not yet reached that level. A byte that arrives while all sixteen entries are taken is discarded, and a sticky overrun bit records the loss.

Flow control is set separately from the flag level. A second programmable threshold drives the `rx_accept` output, which tells the engine whether it may deliver more bytes. The host picks one of four flag levels and one of eight acceptance levels, both in the control register. The overrun bit is read through a line-status register, and reading that register clears it.

Top module: `rx_fifo_trigger`

## Requirements
- R1: The queue stores up to 16 bytes and returns them in arrival order. The fill count never exceeds 16.
- R2: Control register bits [7:6] select the flag level: code 0 gives 1 byte, code 1 gives 4, code 2 gives 8 and code 3 gives 14.
- R3: While the fill count is at or above the flag level, status bit 1 (full) reads 1 and status bit 0 (data ready) reads 0.
- R4: While the fill count is below the flag level, status bit 1 reads 0 and status bit 0 reads 1 exactly when the queue is not empty.
- R5: Control register bits [10:8] select the acceptance level. Codes 0 to 7 give 15, 1, 4, 6, 8, 10, 12 and 14. `rx_accept` is 1 exactly while the fill count is below the selected level.
- R6: A byte presented while 16 bytes are held is discarded, and line-status bit 0 (overrun) is set.
- R7: A host read of the line-status register returns its current value and clears it to zero. An overrun in the same cycle still sets the bit.
- R8: After reset the status register reads 0x0060, the control register reads 0 and the line-status register reads 0. Status bits 6 and 5 always read 1.
- R9: A byte push and a host pop in the same cycle leave the fill count unchanged, and byte order is kept.
- R10: A host pop from an empty queue is ignored: the count stays zero and later bytes are returned normally.
- R11: `reg_sel` selects the register. Select 0 is the data port: its low 8 bits hold the oldest byte, and a read of it pops that byte. Select 1 is the control register, which is read/write and keeps only bits [10:6]; all other bits read 0. Select 2 is the status register, which is read-only. Select 3 is the line-status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Receive engine presents a byte this cycle |
| rx_byte | input | 8 | Byte from the receive engine |
| rx_accept | output | 1 | Fill count is below the acceptance level |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register (combinational) |

## Verification
The assertions assume that `reg_rd` and `reg_wr` are never raised in the same cycle. They also assume the strobes and `rx_valid` are stable around the clock edge. They do not assume that the engine respects `rx_accept`. The overrun path depends on bytes arriving at a full queue, so the stimulus deliberately keeps pushing past the acceptance level. The bench drives every input on the falling edge and raises at most one register strobe per cycle. It reads the flags only through the status register, so the only way to observe fill levels is through the flag and acceptance thresholds.

// File: rtl/rxf_pkg.sv
// Package: shared register-select encoding and threshold decode tables for
// the receive queue. Assumes the flag and acceptance codes are the widths
// fixed by the control register layout (2 and 3 bits).
package rxf_pkg;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_STAT = 2'd2,
        SEL_LINE = 2'd3
    } reg_sel_e;

    localparam int TRIG_LSB = 6;
    localparam int ACC_LSB  = 8;
    localparam logic [15:0] STAT_FIXED = 16'h0060;

    // Flag level selected by the 2-bit trigger code.
    function automatic int trig_level(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

    // Acceptance level selected by the 3-bit flow-control code.
    function automatic int acc_level(input logic [2:0] code);
        if (code == 3'd0) return 15;
        if (code == 3'd1) return 1;
        return 2 * int'(code);
    endfunction

endpackage

// File: rtl/rxf_store.sv
// Module: circular byte store with separate read and write pointers and a
// fill counter. Pushes into a full store are dropped and reported on
// ovf_evt. Pops from an empty store are ignored. Assumes DEPTH is a power of two.
module rxf_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] fill,
    output logic          ovf_evt
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full, empty, push_ok, pop_ok;

    assign full    = (fill == DEPTH_C);
    assign empty   = (fill == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign ovf_evt = push && full;
    assign head_data = mem[rd_ptr];

    // Storage write: place an accepted byte at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Pointer and count update; a push and a pop together leave the count alone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/rxf_flags.sv
// Module: decodes the programmed levels and derives the full, data-ready
// and accept indications from the present fill count. Purely combinational,
// so the flags follow every count change in the same cycle.
module rxf_flags #(
    parameter int CW = 5
) (
    input  logic [CW-1:0] fill,
    input  logic [1:0]    trig_code,
    input  logic [2:0]    acc_code,
    output logic          rdf,
    output logic          dr,
    output logic          accept
);
    import rxf_pkg::*;

    logic [CW-1:0] trig_thr, acc_thr;

    // Threshold decode and flag derivation.
    always_comb begin
        trig_thr = CW'(trig_level(trig_code));
        acc_thr  = CW'(acc_level(acc_code));
        rdf      = (fill >= trig_thr);
        dr       = !rdf && (fill != '0);
        accept   = (fill < acc_thr);
    end

endmodule

// File: rtl/rxf_regs.sv
// Module: host register file. Holds the control fields and the sticky
// overrun bit, multiplexes read data and issues queue pops. Assumes read
// and write strobes are not asserted together.
module rxf_regs #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    reg_sel,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [15:0]   reg_wdata,
    input  logic [DW-1:0] head_data,
    input  logic          rdf,
    input  logic          dr,
    input  logic          ovf_evt,
    output logic [15:0]   reg_rdata,
    output logic [1:0]    trig_code,
    output logic [2:0]    acc_code,
    output logic          fifo_pop,
    output logic          ovr_flag
);
    import rxf_pkg::*;

    reg_sel_e sel;
    assign sel      = reg_sel_e'(reg_sel);
    assign fifo_pop = reg_rd && (sel == SEL_DATA);

    // Control register: keep only the trigger and acceptance fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_code <= '0;
            acc_code  <= '0;
        end else if (reg_wr && sel == SEL_CTRL) begin
            trig_code <= reg_wdata[TRIG_LSB +: 2];
            acc_code  <= reg_wdata[ACC_LSB +: 3];
        end
    end

    // Overrun bit: set by a dropped byte, cleared by a host read; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ovr_flag <= 1'b0;
        else if (ovf_evt)                    ovr_flag <= 1'b1;
        else if (reg_rd && sel == SEL_LINE)  ovr_flag <= 1'b0;
    end

    // Read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_DATA: reg_rdata[DW-1:0] = head_data;
            SEL_CTRL: begin
                reg_rdata[TRIG_LSB +: 2] = trig_code;
                reg_rdata[ACC_LSB +: 3]  = acc_code;
            end
            SEL_STAT: reg_rdata = STAT_FIXED | {14'd0, rdf, dr};
            SEL_LINE: reg_rdata[0] = ovr_flag;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rx_fifo_trigger.sv
// Module: top of the receive queue. Joins the byte store, the flag logic
// and the host register file. Assumes the engine presents at most one
// byte per cycle and may ignore rx_accept (overruns are then recorded).
module rx_fifo_trigger #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    output logic          rx_accept,
    input  logic [1:0]    reg_sel,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata
);

    logic [DW-1:0] head_data;
    logic [CW-1:0] fill;
    logic          ovf_evt, fifo_pop, rdf, dr, ovr_flag;
    logic [1:0]    trig_code;
    logic [2:0]    acc_code;

    rxf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .push(rx_valid), .push_data(rx_byte),
        .pop(fifo_pop), .head_data(head_data), .fill(fill), .ovf_evt(ovf_evt)
    );

    rxf_flags #(.CW(CW)) u_flags (
        .fill(fill), .trig_code(trig_code), .acc_code(acc_code),
        .rdf(rdf), .dr(dr), .accept(rx_accept)
    );

    rxf_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .head_data(head_data),
        .rdf(rdf), .dr(dr), .ovf_evt(ovf_evt), .reg_rdata(reg_rdata),
        .trig_code(trig_code), .acc_code(acc_code), .fifo_pop(fifo_pop),
        .ovr_flag(ovr_flag)
    );

endmodule

// File: rtl/rxf_checker.sv
// Module: property checker for the receive queue, bound to the top module.
// Assumes the register strobes are never raised together.
module rxf_checker #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic          reg_rd,
    input logic [1:0]    reg_sel,
    input logic [CW-1:0] fill,
    input logic          fifo_pop,
    input logic          ovf_evt,
    input logic          ovr_flag,
    input logic          rdf,
    input logic          dr,
    input logic          rx_accept
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= DEPTH_C);

    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rdf && dr));

    assert_ready_means_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dr |-> fill != '0);

    assert_accept_not_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_accept |-> fill < DEPTH_C);

    assert_overrun_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && fill == DEPTH_C) |=> ovr_flag);

    assert_line_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel == 2'd3 && !ovf_evt) |=> !ovr_flag);

    assert_push_pop_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && fifo_pop && fill != '0 && fill != DEPTH_C) |=> fill == $past(fill));

    assert_empty_pop_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0 && fifo_pop && !rx_valid) |=> fill == '0);

endmodule

bind rx_fifo_trigger rxf_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .fill(fill), .fifo_pop(fifo_pop), .ovf_evt(ovf_evt),
    .ovr_flag(ovr_flag), .rdf(rdf), .dr(dr), .rx_accept(rx_accept)
);

// File: tb/sim_rx_fifo_trigger.sv
module sim_rx_fifo_trigger;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_accept;
    logic [1:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    rx_fifo_trigger u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_accept(rx_accept), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic peek(input logic [1:0] sel, output logic [15:0] v);
        @(negedge clk);
        reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] v);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [15:0] ctrl_word(input int t, input int a);
        return 16'((a << 8) | (t << 6));
    endfunction

    task automatic drain(input int n);
        logic [15:0] v;
        for (int i = 0; i < n; i++) rd(2'd0, v);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        peek(2'd2, v); check(v, 16'h0060, "R8 status reset");
        peek(2'd1, v); check(v, 16'h0000, "R8 ctrl reset");
        peek(2'd3, v); check(v, 16'h0000, "R8 line reset");
        check({15'd0, rx_accept}, 16'd1, "R5 accept after reset");
    endtask

    task automatic t_trigger_one();
        logic [15:0] v;
        push(8'hA5);
        peek(2'd2, v); check(v, 16'h0062, "R2 R3 level 1 reached");
        rd(2'd0, v); check(v, 16'h00A5, "R11 data port byte");
        peek(2'd2, v); check(v, 16'h0060, "R4 empty after pop");
    endtask

    task automatic t_trigger_level(input int code, input int lvl);
        logic [15:0] v;
        wr(2'd1, ctrl_word(code, 0));
        peek(2'd1, v); check(v, ctrl_word(code, 0), "R11 ctrl readback");
        for (int i = 0; i < lvl - 1; i++) push(8'(8'h10 + i));
        peek(2'd2, v); check(v, 16'h0061, "R4 below level data ready");
        push(8'(8'h10 + lvl - 1));
        peek(2'd2, v); check(v, 16'h0062, "R3 level reached");
        rd(2'd0, v); check(v, 16'h0010, "R1 oldest first");
        peek(2'd2, v); check(v, 16'h0061, "R4 back below level");
        drain(lvl - 1);
        peek(2'd2, v); check(v, 16'h0060, "R4 drained");
    endtask

    task automatic t_accept();
        logic [15:0] v;
        wr(2'd1, ctrl_word(3, 1));
        check({15'd0, rx_accept}, 16'd1, "R5 level 1 empty");
        push(8'h01);
        check({15'd0, rx_accept}, 16'd0, "R5 level 1 one held");
        drain(1);
        wr(2'd1, ctrl_word(3, 5));
        for (int i = 0; i < 9; i++) push(8'(i));
        check({15'd0, rx_accept}, 16'd1, "R5 level 10 nine held");
        push(8'h09);
        check({15'd0, rx_accept}, 16'd0, "R5 level 10 ten held");
        drain(10);
        wr(2'd1, 16'hFFFF);
        peek(2'd1, v); check(v, 16'h07C0, "R11 ctrl keeps bits 10:6");
        peek(2'd2, v); check(v, 16'h0060, "R11 ctrl write no side effect");
    endtask

    task automatic t_overrun();
        logic [15:0] v;
        wr(2'd1, ctrl_word(0, 0));
        for (int i = 0; i < 14; i++) push(8'(8'h40 + i));
        check({15'd0, rx_accept}, 16'd1, "R5 level 15 at 14");
        push(8'h4E);
        check({15'd0, rx_accept}, 16'd0, "R5 level 15 at 15");
        push(8'h4F);
        peek(2'd3, v); check(v, 16'h0000, "R6 no overrun at 16");
        push(8'hEE);
        peek(2'd3, v); check(v, 16'h0001, "R6 overrun set");
        rd(2'd3, v); check(v, 16'h0001, "R7 read returns value");
        peek(2'd3, v); check(v, 16'h0000, "R7 read clears");
        for (int i = 0; i < 16; i++) begin
            rd(2'd0, v); check(v, 16'(8'h40 + i), "R1 R6 order after drop");
        end
        peek(2'd2, v); check(v, 16'h0060, "R6 dropped byte absent");
    endtask

    task automatic t_push_pop();
        logic [15:0] v;
        wr(2'd1, ctrl_word(1, 0));
        for (int i = 0; i < 4; i++) push(8'(8'h20 + i));
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = 8'h24; reg_sel = 2'd0; reg_rd = 1'b1;
        #1 v = reg_rdata; check(v, 16'h0020, "R9 head during push pop");
        @(negedge clk);
        rx_valid = 1'b0; reg_rd = 1'b0;
        peek(2'd2, v); check(v, 16'h0062, "R9 count still at level");
        rd(2'd0, v);
        peek(2'd2, v); check(v, 16'h0061, "R9 count was four");
        for (int i = 2; i < 5; i++) begin
            rd(2'd0, v); check(v, 16'(8'h20 + i), "R9 order kept");
        end
    endtask

    task automatic t_empty_pop();
        logic [15:0] v;
        rd(2'd0, v);
        rd(2'd0, v);
        peek(2'd2, v); check(v, 16'h0060, "R10 empty pop ignored");
        push(8'h77);
        peek(2'd2, v); check(v, 16'h0061, "R10 one byte after empty pop");
        rd(2'd0, v); check(v, 16'h0077, "R10 byte returned");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_reset();
        t_trigger_one();
        t_trigger_level(1, 4);
        t_trigger_level(2, 8);
        t_trigger_level(3, 14);
        t_accept();
        t_overrun();
        t_push_pop();
        t_empty_pop();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule